// File: doc/BRIEF.md
# Multiplexed Refresh and Auxiliary Packet Link

This block lets a group of fast, edge-only data lanes run with no look-ahead delay. Their steady levels are refreshed over one shared slow serial line instead. On the sending side, the steady level of every fast lane and three slow auxiliary inputs are synchronized and captured together once per frame. They are packed into a framed packet with a parity bit and shifted out one bit at a time over a single serial wire.

On the receiving side, the packet is deserialized and checked. A packet with a bad start pattern or bad parity is dropped, and all outputs keep their previous values. For each fast lane, the output follows the lane's own edge-path value while that value keeps moving. Once the lane has been quiet for a programmable number of cycles, the output is taken from the most recent refreshed level. A wrong edge-path value therefore corrects itself. The auxiliary levels come out of the packet as outputs synchronous to the clock. All three change together, in the cycle a good packet is accepted.

The serial output and serial input are separate ports. The far end is normally fed by the near end's wire, possibly through a barrier model.

Top module: `refresh_aux_link`

## Requirements
- R1: A frame lasts (PKT_BITS+GAP_BITS)*BIT_DIV cycles, where PKT_BITS = N_FAST+6, and each bit is held on `ser_o` for BIT_DIV cycles. A packet is sent most significant bit first, in this order:
  - the start pattern 1 then 0;
  - the fast levels, lane 0 first;
  - aux bits 0, 1 and 2;
  - an even-parity bit over the lane and aux bits.

  GAP_BITS zero bits follow the packet.
- R2: All lane levels and aux bits in one packet are captured in the same clock cycle, after SYNC_STAGES synchronizing flops.
- R3: A change of `edge_i[k]` appears on `fast_o[k]` one clock edge after the edge that sees it, whatever the refreshed level.
- R4: If `edge_i[k]` stays quiet, `fast_o[k]` keeps the edge value through IDLE_CYC further clock edges. It takes the last accepted refreshed level of lane k on the next edge, and then follows that level. A forced-wrong lane therefore recovers.
- R5: Any transition on `edge_i[k]` restarts lane k's quiet window. A lane that toggles more often than the window never shows the refreshed level, and other lanes are unaffected.
- R6: A change of `aux_i` reaches `aux_o` no sooner than PKT_BITS*BIT_DIV cycles and no later than FRAME + PKT_BITS*BIT_DIV + 8 cycles.
- R7: If two aux input edges are at least one frame apart, their output edges keep the same order.
- R8: All aux bits carried by one packet update `aux_o` in the same cycle, so `aux_o` never shows a mix of an old and a new pattern.
- R9: A packet whose parity or start pattern is wrong is discarded. `aux_o` and the refreshed lane levels keep their previous values until the next good packet.
- R10: While reset is asserted, `ser_o`, `fast_o` and `aux_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both ends |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lvl_i | input | N_FAST | Steady levels of the fast lanes at the sending side |
| aux_i | input | 3 | Slow auxiliary inputs at the sending side |
| ser_o | output | 1 | Serial refresh line out |
| ser_i | input | 1 | Serial refresh line in (far end) |
| edge_i | input | N_FAST | Edge-path value of each fast lane at the far end |
| fast_o | output | N_FAST | Merged fast-lane outputs |
| aux_o | output | 3 | Synchronized auxiliary outputs |

## Verification
A wrong bit in the transmit shift register or frame counter shows on `ser_o` within one frame, as a misplaced bit or a wrong frame length. A wrong deserializer phase or parity decision shows as `aux_o` that updates late, never updates, or updates from a corrupted packet. This appears within one maximum aux latency. A wrong quiet counter in one lane moves the cycle in which a forced-wrong `fast_o` bit snaps back to the refreshed level, or stops it from snapping back. That is visible exactly IDLE_CYC+1 edges after the last lane transition.

// File: rtl/rlink_pkg.sv
package rlink_pkg;
  localparam int unsigned AUX_W = 3;
  localparam logic [1:0] START_PAT = 2'b10;

  typedef enum logic {RX_HUNT, RX_RECV} rx_state_e;
endpackage

// File: rtl/rl_sync.sv
module rl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[g] <= '0;
        else         st_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[g] <= '0;
        else         st_q[g] <= st_q[g-1];
      end
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/rl_pkt_tx.sv
module rl_pkt_tx
  import rlink_pkg::*;
#(
  parameter int unsigned N_FAST   = 4,
  parameter int unsigned BIT_DIV  = 4,
  parameter int unsigned GAP_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_FAST-1:0] lvl_i,
  input  logic [AUX_W-1:0]  aux_i,
  output logic              ser_o
);
  localparam int unsigned PL  = N_FAST + AUX_W + 3;
  localparam int unsigned FB  = PL + GAP_BITS;
  localparam int unsigned BW  = $clog2(FB);
  localparam int unsigned DW  = $clog2(BIT_DIV);

  logic [DW-1:0] div_q, div_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [PL-1:0] sh_q, sh_d, pkt;
  logic          ser_q, ser_d;
  logic          tick, load;

  // packet assembly: start, lanes ascending, aux ascending, even parity
  always_comb begin
    pkt = '0;
    pkt[PL-1 -: 2] = START_PAT;
    for (int i = 0; i < N_FAST; i++) pkt[PL-3-i] = lvl_i[i];
    for (int j = 0; j < AUX_W; j++)  pkt[PL-3-N_FAST-j] = aux_i[j];
    pkt[0] = ^{lvl_i, aux_i};
  end

  always_comb begin
    tick  = (div_q == DW'(BIT_DIV-1));
    load  = tick && (bit_q == BW'(FB-1));
    div_d = tick ? '0 : div_q + 1'b1;
    bit_d = bit_q;
    sh_d  = sh_q;
    if (tick) begin
      bit_d = (bit_q == BW'(FB-1)) ? '0 : bit_q + 1'b1;
      sh_d  = load ? pkt : {sh_q[PL-2:0], 1'b0};
    end
    ser_d = sh_q[PL-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      bit_q <= BW'(FB-1);
      sh_q  <= '0;
      ser_q <= 1'b0;
    end else begin
      div_q <= div_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      ser_q <= ser_d;
    end
  end

  assign ser_o = ser_q;

  // R1: the first cycle of a frame is followed by the high start bit on the line
  a_r1_start_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_q == '0 && div_q == '0) |=> ser_o);
endmodule

// File: rtl/rl_pkt_rx.sv
module rl_pkt_rx
  import rlink_pkg::*;
#(
  parameter int unsigned N_FAST  = 4,
  parameter int unsigned BIT_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  output logic [N_FAST-1:0] lvl_o,
  output logic [AUX_W-1:0]  aux_o
);
  localparam int unsigned PL = N_FAST + AUX_W + 3;
  localparam int unsigned DW = $clog2(BIT_DIV);
  localparam int unsigned IW = $clog2(PL);

  rx_state_e         st_q, st_d;
  logic              ln_q, lnp_q;
  logic [DW-1:0]     cd_q, cd_d;
  logic [IW-1:0]     bi_q, bi_d;
  logic [PL-1:0]     sh_q, sh_d;
  logic [N_FAST-1:0] lvl_q, lvl_d;
  logic [AUX_W-1:0]  aux_q, aux_d;
  logic              upd_q, upd_d, bad_q, bad_d;
  logic              pkt_ok;

  always_comb begin
    st_d  = st_q;
    cd_d  = cd_q;
    bi_d  = bi_q;
    sh_d  = sh_q;
    lvl_d = lvl_q;
    aux_d = aux_q;
    upd_d = 1'b0;
    bad_d = 1'b0;
    pkt_ok = 1'b0;
    unique case (st_q)
      RX_HUNT: begin
        if (ln_q && !lnp_q) begin
          st_d = RX_RECV;
          cd_d = DW'(BIT_DIV/2);
          bi_d = '0;
        end
      end
      RX_RECV: begin
        if (cd_q == '0) begin
          sh_d = {sh_q[PL-2:0], ln_q};
          cd_d = DW'(BIT_DIV-1);
          if (bi_q == IW'(PL-1)) begin
            st_d   = RX_HUNT;
            pkt_ok = (sh_d[PL-1 -: 2] == START_PAT) && !(^sh_d[PL-3:0]);
            if (pkt_ok) begin
              for (int i = 0; i < N_FAST; i++) lvl_d[i] = sh_d[PL-3-i];
              for (int j = 0; j < AUX_W; j++)  aux_d[j] = sh_d[PL-3-N_FAST-j];
              upd_d = 1'b1;
            end else begin
              bad_d = 1'b1;
            end
          end else begin
            bi_d = bi_q + 1'b1;
          end
        end else begin
          cd_d = cd_q - 1'b1;
        end
      end
      default: st_d = RX_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_HUNT;
      ln_q  <= 1'b0;
      lnp_q <= 1'b0;
      cd_q  <= '0;
      bi_q  <= '0;
      sh_q  <= '0;
      lvl_q <= '0;
      aux_q <= '0;
      upd_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ln_q  <= ser_i;
      lnp_q <= ln_q;
      cd_q  <= cd_d;
      bi_q  <= bi_d;
      sh_q  <= sh_d;
      lvl_q <= lvl_d;
      aux_q <= aux_d;
      upd_q <= upd_d;
      bad_q <= bad_d;
    end
  end

  assign lvl_o = lvl_q;
  assign aux_o = aux_q;

  // R8: the aux outputs move only in the cycle a whole packet is accepted
  a_r8_aux_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(aux_q) |-> upd_q);
  // R9: a rejected packet leaves every held value untouched
  a_r9_reject_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_q |-> ($stable(aux_q) && $stable(lvl_q)));
endmodule

// File: rtl/rl_lane_merge.sv
module rl_lane_merge #(
  parameter int unsigned IDLE_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic lvl_i,
  output logic fast_o
);
  localparam int unsigned CW = $clog2(IDLE_CYC + 1);

  logic          prev_q, out_q, out_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act, expired;

  always_comb begin
    act     = (edge_i != prev_q);
    expired = (cnt_q == CW'(IDLE_CYC));
    cnt_d   = cnt_q;
    out_d   = out_q;
    if (act) begin
      cnt_d = '0;
      out_d = edge_i;
    end else if (expired) begin
      out_d = lvl_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      out_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= edge_i;
      out_q  <= out_d;
      cnt_q  <= cnt_d;
    end
  end

  assign fast_o = out_q;

  // R3: a seen transition is on the output after the next edge
  a_r3_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i != prev_q) |=> (fast_o == $past(edge_i)));
  // R5: inside the quiet window with no transition the output holds
  a_r5_hold_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_i == prev_q) && (cnt_q != CW'(IDLE_CYC))) |=> $stable(fast_o));
  // R4: once the window is spent the refreshed level is taken
  a_r4_take_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_i == prev_q) && (cnt_q == CW'(IDLE_CYC))) |=> (fast_o == $past(lvl_i)));
endmodule

// File: rtl/refresh_aux_link.sv
module refresh_aux_link
  import rlink_pkg::*;
#(
  parameter int unsigned N_FAST      = 4,
  parameter int unsigned BIT_DIV     = 4,
  parameter int unsigned GAP_BITS    = 2,
  parameter int unsigned IDLE_CYC    = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_FAST-1:0] lvl_i,
  input  logic [2:0]        aux_i,
  output logic              ser_o,
  input  logic              ser_i,
  input  logic [N_FAST-1:0] edge_i,
  output logic [N_FAST-1:0] fast_o,
  output logic [2:0]        aux_o
);
  localparam int unsigned SW = N_FAST + AUX_W;

  logic [1:0]        rst_sq;
  logic              rst_n;
  logic [SW-1:0]     smp;
  logic [N_FAST-1:0] ref_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sq <= 2'b00;
    else         rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_n = rst_sq[1];

  rl_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   ({aux_i, lvl_i}),
    .q_o   (smp)
  );

  rl_pkt_tx #(.N_FAST(N_FAST), .BIT_DIV(BIT_DIV), .GAP_BITS(GAP_BITS)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .lvl_i (smp[N_FAST-1:0]),
    .aux_i (smp[SW-1:N_FAST]),
    .ser_o (ser_o)
  );

  rl_pkt_rx #(.N_FAST(N_FAST), .BIT_DIV(BIT_DIV)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .ser_i (ser_i),
    .lvl_o (ref_lvl),
    .aux_o (aux_o)
  );

  for (genvar k = 0; k < N_FAST; k++) begin : g_lane
    rl_lane_merge #(.IDLE_CYC(IDLE_CYC)) u_merge (
      .clk_i (clk_i),
      .rst_ni(rst_n),
      .edge_i(edge_i[k]),
      .lvl_i (ref_lvl[k]),
      .fast_o(fast_o[k])
    );
  end

  // R10: outputs are cleared while the block is held in reset
  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_n |-> (!ser_o && fast_o == '0 && aux_o == '0));
endmodule

// File: tb/test_refresh_aux_link.sv
module test_refresh_aux_link;
  localparam int CLK_NS = 10;
  localparam int N      = 4;
  localparam int BD     = 4;
  localparam int GAP    = 2;
  localparam int IDLE   = 200;
  localparam int PL     = N + 6;
  localparam int FRAME  = (PL + GAP) * BD;
  localparam int PKT_CYC = PL * BD;
  localparam int BOUND  = FRAME + PKT_CYC + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] lvl = '0, edge_v = '0, fast;
  logic [2:0] aux = '0, aux_out;
  logic ser_o, ser_i;
  logic flip = 1'b0, corrupt = 1'b0, ser_prev = 1'b0, done = 1'b0;
  int pos = 100000, cyc = 0, total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;
  assign ser_i = ser_o ^ flip;

  refresh_aux_link #(.N_FAST(N), .BIT_DIV(BD), .GAP_BITS(GAP), .IDLE_CYC(IDLE))
  i_refresh_aux_link (
    .clk_i(clk), .rst_ni(rst_n), .lvl_i(lvl), .aux_i(aux), .ser_o(ser_o),
    .ser_i(ser_i), .edge_i(edge_v), .fast_o(fast), .aux_o(aux_out));

  // packet position tracker and line corruptor
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (ser_o && !ser_prev && pos >= PKT_CYC) pos = 0;
    else if (pos < 100000) pos = pos + 1;
    ser_prev = ser_o;
    flip = corrupt && pos >= 2*BD && pos < 3*BD;
  end

  function automatic logic [PL-1:0] exp_pkt(input logic [N-1:0] l, input logic [2:0] a);
    logic [PL-1:0] p;
    p = '0;
    p[PL-1] = 1'b1;
    for (int i = 0; i < N; i++) p[PL-3-i] = l[i];
    for (int j = 0; j < 3; j++) p[PL-3-N-j] = a[j];
    p[0] = ^{l, a};
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // returns cycles until aux_out equals target, or -1
  task automatic aux_wait(input logic [2:0] tgt, output int lat);
    lat = -1;
    for (int k = 1; k <= 2*BOUND; k++) begin
      wn(1);
      if (aux_out == tgt) begin lat = k; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int lat, t_a, t_b, mix, t0;
    logic [PL-1:0] ep;
    logic [2:0] old_a, new_a;
    void'($urandom(32'd4711));
    wn(3);
    // R10 reset state
    check(ser_o == 0 && fast == 0 && aux_out == 0, "R10 reset", {fast, aux_out}, 0);
    rst_n = 1'b1;
    wn(FRAME);

    // R1, R2: packet contents and frame period
    lvl = 4'b1011; aux = 3'b110;
    wn(3*FRAME);
    ep = exp_pkt(lvl, aux);
    while (pos != 0) wn(1);
    t0 = cyc;
    for (int b = 0; b < PL; b++) begin
      while (pos != b*BD + BD/2) wn(1);
      check(ser_o == ep[PL-1-b], "R1 packet bit", ser_o, ep[PL-1-b]);
    end
    while (pos != 0) wn(1);
    check(cyc - t0 == FRAME, "R1 frame period", cyc - t0, FRAME);

    // R6, R4, R2 random patterns
    for (int it = 0; it < 12; it++) begin
      logic [2:0] na;
      logic [N-1:0] nl;
      na = 3'($urandom);
      nl = N'($urandom);
      if (na == aux) na = ~aux;
      aux = na; lvl = nl;
      aux_wait(na, lat);
      check(lat >= PKT_CYC && lat <= BOUND, "R6 aux latency", lat, BOUND);
      wn(2);
      check(fast == lvl, "R4 quiet lanes follow level", fast, lvl);
      check(aux_out == na, "R2 aux value", aux_out, na);
    end

    // R3, R4: forced-wrong lane recovers
    edge_v = lvl;
    wn(IDLE + 4);
    check(fast == lvl, "R4 settled", fast, lvl);
    edge_v[0] = ~lvl[0];
    wn(1);
    check(fast[0] == edge_v[0], "R3 edge shown", fast[0], edge_v[0]);
    wn(IDLE);
    check(fast[0] == edge_v[0], "R4 held in window", fast[0], edge_v[0]);
    wn(1);
    check(fast[0] == lvl[0], "R4 recovered", fast[0], lvl[0]);
    check(fast[N-1:1] == lvl[N-1:1], "R3 other lanes", fast, lvl);

    // R5: toggling faster than the window keeps the edge value
    edge_v[1] = ~lvl[1];
    for (int t = 0; t < 6; t++) begin
      wn(IDLE/2);
      check(fast[1] == edge_v[1], "R5 window restart", fast[1], edge_v[1]);
      edge_v[1] = ~edge_v[1];
    end
    wn(IDLE + 3);
    check(fast[1] == lvl[1], "R5 final level", fast[1], lvl[1]);

    // R7: order kept, both directions
    aux = 3'b000;
    wn(2*BOUND);
    aux[0] = 1'b1;
    t_a = -1; t_b = -1;
    for (int k = 1; k <= 3*BOUND; k++) begin
      wn(1);
      if (k == FRAME) aux[2] = 1'b1;
      if (t_a < 0 && aux_out[0]) t_a = k;
      if (t_b < 0 && aux_out[2]) t_b = k;
    end
    check(t_a > 0 && t_b > 0 && t_a < t_b, "R7 order rise", t_a, t_b);
    aux = 3'b111;
    wn(2*BOUND);
    aux[2] = 1'b0;
    t_a = -1; t_b = -1;
    for (int k = 1; k <= 3*BOUND; k++) begin
      wn(1);
      if (k == FRAME) aux[1] = 1'b0;
      if (t_a < 0 && !aux_out[2]) t_a = k;
      if (t_b < 0 && !aux_out[1]) t_b = k;
    end
    check(t_a > 0 && t_b > 0 && t_a < t_b, "R7 order fall", t_a, t_b);

    // R8: simultaneous change, no mixed pattern
    aux = 3'b001;
    wn(2*BOUND);
    old_a = aux_out; new_a = 3'b110;
    aux = new_a; mix = 0;
    for (int k = 0; k < 2*BOUND; k++) begin
      wn(1);
      if (aux_out != old_a && aux_out != new_a) mix++;
    end
    check(mix == 0 && aux_out == new_a, "R8 atomic aux", aux_out, new_a);

    // R9: corrupted packets dropped, held values visible
    edge_v = lvl;
    wn(IDLE + 4);
    old_a = aux_out;
    corrupt = 1'b1;
    wn(FRAME);
    aux = ~old_a;
    lvl = ~lvl;
    wn(4*FRAME);
    check(aux_out == old_a, "R9 aux held", aux_out, old_a);
    check(fast == ~lvl, "R9 level held", fast, ~lvl);
    corrupt = 1'b0;
    aux_wait(~old_a, lat);
    check(lat > 0 && lat <= BOUND, "R9 resume", lat, BOUND);
    wn(2);
    check(fast == lvl, "R9 level resume", fast, lvl);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule